// File: doc/BRIEF.md
# Basis Blade Product Resolver

This block works out where the product of two basis blades of an n-dimensional geometric algebra lands, and with which sign. Each operand blade is a bitmap: bit i set means basis vector e(i+1) is part of the blade, so bitmap 0 is the scalar and, for three dimensions, the eight bitmaps cover the scalar, the three vectors, the three bivectors and the pseudoscalar. The result blade is the bitwise exclusive-or of the two operand bitmaps, because every basis vector squares to +1 and shared vectors drop out of the product.

The sign comes from a small gate network rather than from a stored product table. Bringing the concatenated vector list into ascending order costs one sign flip per exchange of two distinct vectors; an AND gate flags each pair (vector i from the left operand, vector j from the right operand, with i above j), and the parity of all flags is the sign. A multiply-accumulate datapath uses the resolved blade as the destination slot and the sign to add or subtract the coefficient product. The dimension is a parameter from 1 to 5, and an optional register stage can be placed on the outputs.

Top module: `blade_product`

## Requirements
- R1: The result bitmap `blade_o` equals the bitwise XOR of `blade_a_i` and `blade_b_i`.
- R2: When either operand bitmap is 0 (the scalar), the result bitmap equals the other operand and `neg_o` is 0.
- R3: A blade multiplied by itself gives bitmap 0; `neg_o` is 1 exactly when the blade's popcount k has k(k-1)/2 odd (k mod 4 is 2 or 3), so the 3-D pseudoscalar 7 squared gives bitmap 0 with `neg_o` = 1.
- R4: `neg_o` (1 = negative) equals the parity of the number of pairs (i, j) with bit i set in A, bit j set in B and i greater than j.
- R5: For two different single vectors, `neg_o` is 0 when the left operand has the lower index and 1 otherwise (bitmap 1 times 2 gives +3, 2 times 1 gives -3).
- R6: The bivector 3 (e1e2) times the bivector 6 (e2e3) gives bitmap 5 (e1e3) with `neg_o` = 0.
- R7: With `REG_OUT` = 1 the outputs show the result of the inputs present at the previous rising clock edge; while `rst_ni` is low they are bitmap 0 with `neg_o` = 0.
- R8: `DIMS` may be set from 1 to 5; any other value stops elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low synchronous reset of the output register |
| blade_a_i | input | DIMS | Left operand blade bitmap |
| blade_b_i | input | DIMS | Right operand blade bitmap |
| blade_o | output | DIMS | Result blade bitmap |
| neg_o | output | 1 | Result sign, 1 when negative |

## Verification
On every cycle the assertions relate the resolver's combinational result to the operands: the popcount of the result against the operands' overlap, scalar operands on either side, the sign of a blade squared, the anticommuting of distinct single vectors, and the one-cycle delay of the output register. The full sign rule for arbitrary mixed-grade pairs, the specific bivector product, and the reset value seen at the ports are shown only by the bench, which sweeps every operand pair and random pairs against a reference that sorts the vector list by exchanges.

// File: rtl/blade_pkg.sv
package blade_pkg;
    // Largest supported algebra dimension.
    localparam int unsigned MAX_DIMS = 5;

    typedef logic [MAX_DIMS-1:0] blade_bits_t;

    // Resolved product: destination blade and its sign.
    typedef struct packed {
        logic        neg;
        blade_bits_t idx;
    } blade_res_t;
endpackage

// File: rtl/blade_index_xor.sv
module blade_index_xor #(
    parameter int unsigned DIMS = 3
) (
    input  logic [DIMS-1:0] lhs_i,
    input  logic [DIMS-1:0] rhs_i,
    output logic [DIMS-1:0] idx_o
);
    // Shared vectors square to +1 and vanish; the rest survive.
    for (genvar k = 0; k < DIMS; k++) begin : g_bit
        assign idx_o[k] = lhs_i[k] ^ rhs_i[k];
    end
endmodule

// File: rtl/blade_swap_parity.sv
module blade_swap_parity #(
    parameter int unsigned DIMS = 3
) (
    input  logic [DIMS-1:0] lhs_i,
    input  logic [DIMS-1:0] rhs_i,
    output logic            neg_o
);
    // One flag per left vector: parity of right vectors that must pass it.
    logic [DIMS-1:0] cross_par;

    for (genvar i = 0; i < DIMS; i++) begin : g_row
        if (i == 0) begin : g_lowest
            assign cross_par[i] = 1'b0;
        end else begin : g_upper
            logic [i-1:0] pair_hit;
            for (genvar j = 0; j < i; j++) begin : g_col
                assign pair_hit[j] = lhs_i[i] & rhs_i[j];
            end
            assign cross_par[i] = ^pair_hit;
        end
    end

    assign neg_o = ^cross_par;
endmodule

// File: rtl/blade_out_stage.sv
module blade_out_stage
    import blade_pkg::*;
#(
    parameter int unsigned DIMS    = 3,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [DIMS-1:0] idx_i,
    input  logic            neg_i,
    output logic [DIMS-1:0] idx_o,
    output logic            neg_o
);
    blade_res_t res_d;
    blade_res_t res_q;

    always_comb begin
        res_d           = '0;
        res_d.neg       = neg_i;
        res_d.idx       = '0;
        res_d.idx[DIMS-1:0] = idx_i;
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                res_q <= '0;
            end else begin
                res_q <= res_d;
            end
        end
        assign idx_o = res_q.idx[DIMS-1:0];
        assign neg_o = res_q.neg;
    end else begin : g_comb
        assign res_q = res_d;
        assign idx_o = res_d.idx[DIMS-1:0];
        assign neg_o = res_d.neg;
    end
endmodule

// File: rtl/blade_product.sv
module blade_product
    import blade_pkg::*;
#(
    parameter int unsigned DIMS    = 3,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [DIMS-1:0] blade_a_i,
    input  logic [DIMS-1:0] blade_b_i,
    output logic [DIMS-1:0] blade_o,
    output logic            neg_o
);
    // R8: dimension range guard
    if (DIMS < 1 || DIMS > MAX_DIMS) begin : g_bad_dims
        $error("blade_product: DIMS must lie in 1..%0d", MAX_DIMS);
    end

    logic [DIMS-1:0] core_idx;
    logic            core_neg;

    blade_index_xor #(.DIMS(DIMS)) u_index (
        .lhs_i (blade_a_i),
        .rhs_i (blade_b_i),
        .idx_o (core_idx)
    );

    blade_swap_parity #(.DIMS(DIMS)) u_sign (
        .lhs_i (blade_a_i),
        .rhs_i (blade_b_i),
        .neg_o (core_neg)
    );

    blade_out_stage #(.DIMS(DIMS), .REG_OUT(REG_OUT)) u_out (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .idx_i  (core_idx),
        .neg_i  (core_neg),
        .idx_o  (blade_o),
        .neg_o  (neg_o)
    );

    // Assertion helper: set once a full cycle out of reset has passed.
    logic live_d, live_q;
    always_comb live_d = 1'b1;
    always_ff @(posedge clk_i) begin
        if (!rst_ni) live_q <= 1'b0;
        else         live_q <= live_d;
    end

    // R1
    index_popcount_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(core_idx) == $countones(blade_a_i) + $countones(blade_b_i)
                                - 2 * $countones(blade_a_i & blade_b_i));

    // R2
    scalar_left_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (blade_a_i == '0) |-> (core_idx == blade_b_i && !core_neg));

    // R2
    scalar_right_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (blade_b_i == '0) |-> (core_idx == blade_a_i && !core_neg));

    // R3
    self_square_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (blade_a_i == blade_b_i) |->
            (core_idx == '0 && core_neg == (($countones(blade_a_i) % 4) >= 2)));

    // R5
    anticommute_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($countones(blade_a_i) == 1 && $countones(blade_b_i) == 1 && blade_a_i != blade_b_i)
            |-> (core_neg == (blade_a_i > blade_b_i)));

    if (REG_OUT) begin : g_delay_chk
        // R7
        reg_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            live_q |-> (blade_o == $past(core_idx) && neg_o == $past(core_neg)));
    end
endmodule

// File: tb/sim_blade_product.sv
module sim_blade_product;
    localparam int unsigned DIMS  = 3;
    localparam int unsigned NBLD  = 1 << DIMS;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [DIMS-1:0] a = '0;
    logic [DIMS-1:0] b = '0;
    logic [DIMS-1:0] blade;
    logic            neg;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    blade_product #(.DIMS(DIMS), .REG_OUT(1'b1)) u0 (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .blade_a_i (a),
        .blade_b_i (b),
        .blade_o   (blade),
        .neg_o     (neg)
    );

    // Reference: write out the vector list, bubble sort it counting swaps
    // of distinct vectors, then cancel equal neighbours.
    function automatic logic [DIMS:0] ref_product(input logic [DIMS-1:0] x,
                                                  input logic [DIMS-1:0] y);
        int lst[2*DIMS];
        int n = 0;
        int swaps = 0;
        logic [DIMS-1:0] idx = '0;
        for (int i = 0; i < DIMS; i++) if (x[i]) begin lst[n] = i; n++; end
        for (int i = 0; i < DIMS; i++) if (y[i]) begin lst[n] = i; n++; end
        for (int p = 0; p < n; p++) begin
            for (int q = 0; q + 1 < n - p; q++) begin
                if (lst[q] > lst[q+1]) begin
                    int t = lst[q];
                    lst[q] = lst[q+1];
                    lst[q+1] = t;
                    swaps++;
                end
            end
        end
        for (int i = 0; i < n; i++) idx[lst[i]] = ~idx[lst[i]];
        return {swaps[0], idx};
    endfunction

    task automatic apply_check(input logic [DIMS-1:0] x, input logic [DIMS-1:0] y,
                               input string req);
        logic [DIMS:0] exp;
        @(negedge clk);
        a = x;
        b = y;
        @(negedge clk);
        exp = ref_product(x, y);
        checks++;
        if ({neg, blade} !== exp) begin
            errors++;
            $display("FAIL %s: a=%0d b=%0d got neg=%0b blade=%0d expected neg=%0b blade=%0d",
                     req, x, y, neg, blade, exp[DIMS], exp[DIMS-1:0]);
        end
    endtask

    task automatic expect_val(input logic [DIMS-1:0] x, input logic [DIMS-1:0] y,
                              input logic [DIMS-1:0] eb, input logic en, input string req);
        @(negedge clk);
        a = x;
        b = y;
        @(negedge clk);
        checks++;
        if (blade !== eb || neg !== en) begin
            errors++;
            $display("FAIL %s: a=%0d b=%0d got neg=%0b blade=%0d expected neg=%0b blade=%0d",
                     req, x, y, neg, blade, en, eb);
        end
    endtask

    initial begin
        void'($urandom(32'd2718));
        // R7: reset value at the ports while reset is held, inputs nonzero
        a = 3'd7;
        b = 3'd7;
        repeat (3) @(negedge clk);
        checks++;
        if (blade !== '0 || neg !== 1'b0) begin
            errors++;
            $display("FAIL R7 reset: got neg=%0b blade=%0d expected neg=0 blade=0", neg, blade);
        end
        rst_n = 1'b1;

        // R5 and R6 worked cases
        expect_val(3'd1, 3'd2, 3'd3, 1'b0, "R5 e1*e2");
        expect_val(3'd2, 3'd1, 3'd3, 1'b1, "R5 e2*e1");
        expect_val(3'd4, 3'd1, 3'd5, 1'b1, "R5 e3*e1");
        expect_val(3'd3, 3'd6, 3'd5, 1'b0, "R6 e1e2*e2e3");
        // R3 squares
        expect_val(3'd7, 3'd7, 3'd0, 1'b1, "R3 pseudoscalar squared");
        expect_val(3'd5, 3'd5, 3'd0, 1'b1, "R3 bivector squared");
        expect_val(3'd4, 3'd4, 3'd0, 1'b0, "R3 vector squared");
        // R2 scalar operand on each side
        expect_val(3'd0, 3'd6, 3'd6, 1'b0, "R2 scalar left");
        expect_val(3'd7, 3'd0, 3'd7, 1'b0, "R2 scalar right");

        // R1 and R4: every pair against the sorting reference
        for (int i = 0; i < NBLD; i++) begin
            for (int j = 0; j < NBLD; j++) begin
                apply_check(i[DIMS-1:0], j[DIMS-1:0], "R1/R4 sweep");
            end
        end

        // R1 and R4: random pairs, including back-to-back changes
        for (int k = 0; k < 200; k++) begin
            apply_check($urandom() % NBLD, $urandom() % NBLD, "R4 random");
        end

        // R7: output holds the previous edge's operands, one cycle late
        @(negedge clk);
        a = 3'd2;
        b = 3'd1;
        @(negedge clk);
        a = 3'd1;
        b = 3'd2;
        checks++;
        if (blade !== 3'd3 || neg !== 1'b1) begin
            errors++;
            $display("FAIL R7 delay: got neg=%0b blade=%0d expected neg=1 blade=3", neg, blade);
        end
        @(negedge clk);
        checks++;
        if (blade !== 3'd3 || neg !== 1'b0) begin
            errors++;
            $display("FAIL R7 update: got neg=%0b blade=%0d expected neg=0 blade=3", neg, blade);
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule